// File: doc/BRIEF.md
# Half-Duplex SPI Master Engine

This block is a master-only serial engine that moves words of 1 to 16 bits between the chip and one slave. It moves data in one direction at a time. In transmit direction, software fills a 64-entry, 16-bit FIFO and the engine drains it onto MOSI. In receive direction, the engine clocks dummy bits out with MOSI held low and captures MISO into the same FIFO. It stops when the FIFO fills or when a programmed number of words has been taken.

Clock polarity and phase, bit order, word length and the SCK divider come from static control inputs. These inputs are changed only while the engine is idle and the FIFO is empty. The slave can hold off the next word with a busy line. This line is synchronised and looked at only between words. When received words sit in the FIFO with no serial or FIFO activity for a programmable number of cycles, an interrupt flags them so that software can collect the tail of a message.

Top module: `spi_hd_master`

## Requirements
- R1: The pair {cpol, cpha} selects the SPI mode. SCK idles at cpol. Data is sampled on the rising SCK edge when cpol equals cpha, otherwise on the falling edge. With cpha=0 the first bit is on MOSI before the first edge.
- R2: With dirRx=0, every word pushed into the FIFO is shifted out on MOSI, in push order. Each word is sent once.
- R3: With dirRx=1, a start pulse loads a word count from rxWords. The engine receives that many words into the FIFO, and MOSI stays low during the whole receive.
- R4: The word length is wordLen+1 bits, for any value from 1 to 16. Words are packed right-aligned in the 16-bit FIFO entries.
- R5: With lsbFirst=1, bit 0 of a word is the first bit on the wire. With lsbFirst=0, bit wordLen goes first. The same rule applies in both directions.
- R6: The FIFO holds 64 words. In receive, no new word starts while it is full. Reception resumes with the remaining count once software pops entries.
- R7: While slaveBusy is high, no new word starts. A word already in progress completes.
- R8: With timeoutVal nonzero in receive, timeoutIrq rises about timeoutVal cycles after the last FIFO push, pop or SCK edge if the FIFO is not empty. It stays high until the FIFO is read to empty.
- R9: The SCK period is 2*divHalf system clocks, and a divHalf of 0 acts as 1.
- R10: pushValid has no effect while dirRx=1, and popReq has no effect while dirRx=0.
- R11: After reset the engine is idle: SCK low, MOSI low, FIFO empty and not full, interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| dirRx | input | 1 | 0 transmit from FIFO, 1 receive into FIFO |
| wordLen | input | 4 | Word length minus one |
| lsbFirst | input | 1 | 1 sends and receives bit 0 first |
| divHalf | input | 8 | SCK half period in system clocks |
| rxWords | input | 8 | Number of words to receive, loaded by start |
| start | input | 1 | Loads the receive word count |
| timeoutVal | input | 16 | Idle cycles before the interrupt, 0 disables it |
| pushValid | input | 1 | Write pushData into the FIFO (transmit only) |
| pushData | input | 16 | Word to transmit |
| full | output | 1 | FIFO holds 64 words |
| popReq | input | 1 | Remove the head word (receive only) |
| popData | output | 16 | FIFO head word |
| empty | output | 1 | FIFO holds no word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| slaveBusy | input | 1 | Slave asks to hold the next word |
| active | output | 1 | A word is being shifted |
| timeoutIrq | output | 1 | Received data left idle in FIFO |

## Verification
A wrong edge counter or bit index shows at the ports within one word. The slave model captures a bit in the wrong position, or the SCK period and edge count come out wrong. A FIFO pointer or level fault shows as a missing, repeated or out-of-order word, or as reception that does not stop at 64 words or does not resume after draining. A fault in the busy synchroniser or in the timeout counter only shows over tens to hundreds of cycles. The bench therefore looks for a started word while busy is high, and checks the interrupt level well before and well after the programmed timeout.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
  localparam int MAX_W = 16;
  localparam int POS_W = $clog2(MAX_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FINISH} state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;    // begin a word
    logic             sample;  // capture MISO now
    logic             push;    // store received word
    logic             active;  // word in progress
    logic [POS_W-1:0] inPos;   // bit position for capture
    logic [POS_W-1:0] outPos;  // bit position on MOSI
  } strobe_t;
endpackage

// File: rtl/spi_hd_ctrl.sv
module spi_hd_ctrl
  import spi_hd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             dirRx,
  input  logic [POS_W-1:0] wordLen,
  input  logic             lsbFirst,
  input  logic [DIV_W-1:0] divHalf,
  input  logic [CNT_W-1:0] rxWords,
  input  logic             start,
  input  logic [TO_W-1:0]  timeoutVal,
  input  logic             slaveBusy,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic             popReq,
  output logic             sck,
  output logic             timeoutIrq,
  output strobe_t          stb
);
  localparam int EW = POS_W + 2;

  state_t           state;
  logic             busyS1, busyS2;
  logic [DIV_W-1:0] halfCnt, divEff;
  logic [EW-1:0]    edgeCnt, edgeM1;
  logic [CNT_W-1:0] rxLeft;
  logic [TO_W-1:0]  toCnt;
  logic             tick, lastEdge, go, wantTx, wantRx, activity;
  logic [POS_W-1:0] inK, outK;

  function automatic logic [POS_W-1:0] mapPos(input logic [POS_W-1:0] k,
                                               input logic lsb,
                                               input logic [POS_W-1:0] len);
    return lsb ? k : len - k;
  endfunction

  always_comb begin
    divEff   = (divHalf == '0) ? DIV_W'(1) : divHalf;
    tick     = (state == ST_SHIFT) && (halfCnt == '0);
    lastEdge = edgeCnt == {1'b0, wordLen, 1'b1};
    wantTx   = !dirRx && !fifoEmpty;
    wantRx   = dirRx && (rxLeft != '0) && !fifoFull;
    go       = (state == ST_IDLE) && !busyS2 && (wantTx || wantRx);
    edgeM1   = edgeCnt - 1'b1;
    inK      = edgeCnt[POS_W:1];
    outK     = cpha ? ((edgeCnt == '0) ? '0 : edgeM1[POS_W:1]) : edgeCnt[POS_W:1];
    stb.load   = go;
    stb.sample = tick && (edgeCnt[0] == cpha);
    stb.push   = (state == ST_FINISH) && dirRx;
    stb.active = state != ST_IDLE;
    stb.inPos  = mapPos(inK, lsbFirst, wordLen);
    stb.outPos = mapPos(outK, lsbFirst, wordLen);
    activity   = stb.push || tick || (popReq && dirRx && !fifoEmpty);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyS1 <= 1'b0;
      busyS2 <= 1'b0;
    end else begin
      busyS1 <= slaveBusy;
      busyS2 <= busyS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sck     <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sck     <= cpol;
          edgeCnt <= '0;
          if (go) begin
            state   <= ST_SHIFT;
            halfCnt <= divEff - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck     <= ~sck;
            edgeCnt <= edgeCnt + 1'b1;
            halfCnt <= divEff - 1'b1;
            if (lastEdge) state <= ST_FINISH;
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxLeft <= '0;
    else if (start) rxLeft <= rxWords;
    else if (go && dirRx) rxLeft <= rxLeft - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt      <= '0;
      timeoutIrq <= 1'b0;
    end else begin
      if (!dirRx || fifoEmpty || activity) toCnt <= '0;
      else if (toCnt != timeoutVal) toCnt <= toCnt + 1'b1;
      if (fifoEmpty) timeoutIrq <= 1'b0;
      else if (dirRx && (timeoutVal != '0) && (toCnt == timeoutVal)) timeoutIrq <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_hd_dpath.sv
module spi_hd_dpath
  import spi_hd_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirRx,
  input  logic             pushValid,
  input  logic [MAX_W-1:0] pushData,
  input  logic             popReq,
  input  strobe_t          stb,
  input  logic             miso,
  output logic             full,
  output logic             empty,
  output logic [MAX_W-1:0] popData,
  output logic             mosi
);
  localparam int AW = $clog2(DEPTH);

  logic [MAX_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic [MAX_W-1:0] txWord, rxWord, wrData;
  logic             wrEn, rdEn;

  always_comb begin
    full    = count == (AW+1)'(DEPTH);
    empty   = count == '0;
    wrEn    = (dirRx ? stb.push : pushValid) && !full;
    rdEn    = (dirRx ? popReq : stb.load) && !empty;
    wrData  = dirRx ? rxWord : pushData;
    popData = mem[rdPtr];
    mosi    = (!dirRx && stb.active) ? txWord[stb.outPos] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= wrPtr + 1'b1;
      if (rdEn) rdPtr <= rdPtr + 1'b1;
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord <= '0;
      rxWord <= '0;
    end else begin
      if (stb.load && !dirRx) txWord <= mem[rdPtr];
      if (stb.load && dirRx) rxWord <= '0;
      else if (stb.sample && dirRx) rxWord[stb.inPos] <= miso;
    end
  end
endmodule

// File: rtl/spi_hd_master.sv
module spi_hd_master
  import spi_hd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DIV_W = 8,
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             dirRx,
  input  logic [POS_W-1:0] wordLen,
  input  logic             lsbFirst,
  input  logic [DIV_W-1:0] divHalf,
  input  logic [CNT_W-1:0] rxWords,
  input  logic             start,
  input  logic [TO_W-1:0]  timeoutVal,
  input  logic             pushValid,
  input  logic [MAX_W-1:0] pushData,
  output logic             full,
  input  logic             popReq,
  output logic [MAX_W-1:0] popData,
  output logic             empty,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  input  logic             slaveBusy,
  output logic             active,
  output logic             timeoutIrq
);
  strobe_t stb;

  spi_hd_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W), .TO_W(TO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .dirRx(dirRx),
    .wordLen(wordLen), .lsbFirst(lsbFirst), .divHalf(divHalf),
    .rxWords(rxWords), .start(start), .timeoutVal(timeoutVal),
    .slaveBusy(slaveBusy), .fifoEmpty(empty), .fifoFull(full),
    .popReq(popReq), .sck(sck), .timeoutIrq(timeoutIrq), .stb(stb)
  );

  spi_hd_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .pushValid(pushValid),
    .pushData(pushData), .popReq(popReq), .stb(stb), .miso(miso),
    .full(full), .empty(empty), .popData(popData), .mosi(mosi)
  );

  assign active = stb.active;
endmodule

// File: rtl/spi_hd_master_chk.sv
module spi_hd_master_chk (
  input logic clk,
  input logic rstN,
  input logic cpol,
  input logic dirRx,
  input logic slaveBusy,
  input logic sck,
  input logic mosi,
  input logic active,
  input logic full,
  input logic empty,
  input logic timeoutIrq
);
  // R1: idle SCK follows polarity once settled
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!active && $past(!active) && $stable(cpol) && $past(rstN)) |-> (sck == cpol));

  // R3: dummy bits are zero in receive
  a_r3_mosi_low_rx: assert property (@(posedge clk) disable iff (!rstN)
    dirRx |-> !mosi);

  // R6: level flags exclusive
  a_r6_full_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R7: no word begins after a synchronised busy
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> !$past(slaveBusy, 3));

  // R8: interrupt never follows an empty FIFO
  a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $past(empty) |-> !timeoutIrq);
endmodule

bind spi_hd_master spi_hd_master_chk u_chk (
  .clk(clk), .rstN(rstN), .cpol(cpol), .dirRx(dirRx), .slaveBusy(slaveBusy),
  .sck(sck), .mosi(mosi), .active(active), .full(full), .empty(empty),
  .timeoutIrq(timeoutIrq)
);

// File: tb/spi_hd_master_test.sv
`timescale 1ns/1ps
module spi_hd_master_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpol = 0, cpha = 0, dirRx = 0, lsbFirst = 0, start = 0;
  logic [3:0] wordLen = 4'd7;
  logic [7:0] divHalf = 8'd1, rxWords = 8'd0;
  logic [15:0] timeoutVal = 16'd0;
  logic pushValid = 0, popReq = 0, slaveBusy = 0;
  logic [15:0] pushData = 16'd0;
  logic full, empty, sck, mosi, miso, active, timeoutIrq;
  logic [15:0] popData;

  int errors = 0, checks = 0;
  bit doneAll = 0;

  always #4 clk = ~clk;

  spi_hd_master uut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .dirRx(dirRx),
    .wordLen(wordLen), .lsbFirst(lsbFirst), .divHalf(divHalf),
    .rxWords(rxWords), .start(start), .timeoutVal(timeoutVal),
    .pushValid(pushValid), .pushData(pushData), .full(full),
    .popReq(popReq), .popData(popData), .empty(empty), .sck(sck),
    .mosi(mosi), .miso(miso), .slaveBusy(slaveBusy), .active(active),
    .timeoutIrq(timeoutIrq)
  );

  // slave model
  logic [15:0] capQ [128];
  logic [15:0] slvQ [128];
  logic [15:0] sAcc;
  int capN, sBit, slvN, edgeN, mosiHighRx;
  int clkCnt = 0, lastRise, minPeriod;

  always @(posedge clk) begin
    clkCnt++;
    if (dirRx && mosi) mosiHighRx++;
  end

  always @(sck) begin
    if (active) begin
      edgeN++;
      if (sck == (cpol == cpha)) begin
        int pos;
        pos = lsbFirst ? sBit : (int'(wordLen) - sBit);
        sAcc[pos] = mosi;
        sBit++;
        if (sBit == int'(wordLen) + 1) begin
          capQ[capN % 128] = sAcc;
          capN++;
          sAcc = 16'd0;
          sBit = 0;
          slvN++;
        end
      end
      if (sck) begin
        if (lastRise >= 0 && (clkCnt - lastRise) < minPeriod) minPeriod = clkCnt - lastRise;
        lastRise = clkCnt;
      end
    end
  end

  always_comb begin
    int p;
    p = lsbFirst ? sBit : (int'(wordLen) - sBit);
    miso = slvQ[slvN % 128][p & 15];
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clrSlave();
    capN = 0; sBit = 0; slvN = 0; sAcc = 16'd0; edgeN = 0;
    mosiHighRx = 0; lastRise = -1; minPeriod = 9999;
    for (int i = 0; i < 128; i++) slvQ[i] = (16'h9E37 * 16'(i + 1)) ^ 16'(i);
  endtask

  task automatic setup(input int mode, input int len, input bit lsb, input int div, input bit rx);
    @(negedge clk);
    cpol = mode[1]; cpha = mode[0]; wordLen = 4'(len - 1);
    lsbFirst = lsb; divHalf = 8'(div); dirRx = rx;
    repeat (3) @(negedge clk);
    clrSlave();
  endtask

  task automatic pushWord(input logic [15:0] w);
    @(negedge clk); pushValid = 1; pushData = w;
    @(negedge clk); pushValid = 0;
  endtask

  task automatic popWord(output logic [15:0] w);
    @(negedge clk); w = popData; popReq = 1;
    @(negedge clk); popReq = 0;
  endtask

  task automatic waitQuiet();
    int idle = 0;
    for (int n = 0; n < 20000 && idle < 40; n++) begin
      @(negedge clk);
      idle = active ? 0 : idle + 1;
    end
  endtask

  function automatic logic [15:0] txVal(input int i, input int len, input logic [15:0] base);
    logic [15:0] m;
    m = (len == 16) ? 16'hFFFF : 16'((1 << len) - 1);
    return (base ^ 16'(i * 16'h3C71)) & m;
  endfunction

  task automatic runTx(input int mode, input int len, input bit lsb, input int div,
                       input int n, input logic [15:0] base, input string req);
    setup(mode, len, lsb, div, 1'b0);
    for (int i = 0; i < n; i++) pushWord(txVal(i, len, base));
    waitQuiet();
    chk(capN == n, {req, " word count"}, capN, n);
    chk(edgeN == 2 * len * n, {req, " sck edges"}, edgeN, 2 * len * n);
    for (int i = 0; i < n; i++)
      chk(capQ[i] == txVal(i, len, base), {req, " tx data"}, capQ[i], txVal(i, len, base));
    chk(empty && sck == mode[1], {req, " idle after tx"}, {empty, sck}, {1'b1, mode[1]});
  endtask

  task automatic runRx(input int mode, input int len, input bit lsb, input int n, input string req);
    logic [15:0] w, m;
    m = (len == 16) ? 16'hFFFF : 16'((1 << len) - 1);
    setup(mode, len, lsb, 1, 1'b1);
    @(negedge clk); rxWords = 8'(n); start = 1;
    @(negedge clk); start = 0;
    waitQuiet();
    chk(capN == n, {req, " R3 words clocked"}, capN, n);
    chk(mosiHighRx == 0, "R3 mosi low in receive", mosiHighRx, 0);
    for (int i = 0; i < n; i++) begin
      popWord(w);
      chk(w == (slvQ[i] & m), {req, " rx data"}, w, slvQ[i] & m);
    end
    @(negedge clk);
    chk(empty, {req, " empty after drain"}, empty, 1);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(!sck && !mosi && empty && !full && !timeoutIrq && !active, "R11 reset state",
        {sck, mosi, empty, full, timeoutIrq, active}, 6'b001000);
  endtask

  task automatic tFull();
    logic [15:0] w;
    setup(0, 4, 1'b0, 1, 1'b1);
    @(negedge clk); rxWords = 8'd70; start = 1;
    @(negedge clk); start = 0;
    waitQuiet();
    chk(full && capN == 64, "R6 stop at full", capN, 64);
    for (int i = 0; i < 64; i++) begin
      popWord(w);
      if (w != (slvQ[i] & 16'hF)) chk(0, "R6 rx data after full", w, slvQ[i] & 16'hF);
    end
    waitQuiet();
    chk(capN == 70, "R6 resume after drain", capN, 70);
    for (int i = 64; i < 70; i++) begin
      popWord(w);
      chk(w == (slvQ[i] & 16'hF), "R6 resumed data", w, slvQ[i] & 16'hF);
    end
    chk(empty, "R6 empty at end", empty, 1);
  endtask

  task automatic tIgnored();
    setup(0, 8, 1'b0, 1, 1'b1);
    pushWord(16'h00AA);
    repeat (4) @(negedge clk);
    chk(empty && edgeN == 0, "R10 push ignored in receive", {empty, 8'(edgeN)}, 9'h100);
  endtask

  task automatic tBusy();
    setup(0, 8, 1'b0, 4, 1'b0);
    slaveBusy = 1;
    pushWord(16'h005A);
    pushWord(16'h00C3);
    repeat (200) @(negedge clk);
    chk(edgeN == 0 && !empty, "R7 busy blocks start", edgeN, 0);
    @(negedge clk); popReq = 1;
    @(negedge clk); popReq = 0;
    @(negedge clk);
    chk(!empty, "R10 pop ignored in transmit", empty, 0);
    slaveBusy = 0;
    for (int n = 0; n < 1000 && !active; n++) @(negedge clk);
    slaveBusy = 1;
    waitQuiet();
    chk(capN == 1 && capQ[0] == 16'h005A, "R7 word in progress completes", capN, 1);
    slaveBusy = 0;
    waitQuiet();
    chk(capN == 2 && capQ[1] == 16'h00C3, "R7 resume after busy", capN, 2);
    chk(empty, "R10 both words sent once", empty, 1);
  endtask

  task automatic tDivider();
    runTx(0, 8, 1'b0, 3, 2, 16'h0036, "R9 divide 6");
    chk(minPeriod == 6, "R9 sck period", minPeriod, 6);
    runTx(1, 6, 1'b1, 0, 1, 16'h0015, "R9 divide zero");
    chk(minPeriod == 2, "R9 zero acts as one", minPeriod, 2);
  endtask

  task automatic tTimeout();
    logic [15:0] w;
    setup(0, 8, 1'b0, 1, 1'b1);
    timeoutVal = 16'd100;
    @(negedge clk); rxWords = 8'd2; start = 1;
    @(negedge clk); start = 0;
    for (int n = 0; n < 2000 && !(capN == 2 && !active); n++) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(!timeoutIrq, "R8 no irq before timeout", timeoutIrq, 0);
    repeat (100) @(negedge clk);
    chk(timeoutIrq, "R8 irq after timeout", timeoutIrq, 1);
    popWord(w);
    @(negedge clk);
    chk(timeoutIrq, "R8 irq held until empty", timeoutIrq, 1);
    popWord(w);
    @(negedge clk);
    chk(!timeoutIrq && empty, "R8 irq clears when empty", timeoutIrq, 0);
    timeoutVal = 16'd0;
  endtask

  initial begin
    clrSlave();
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    runTx(0, 8, 1'b0, 1, 3, 16'h00A5, "R1 R2 mode0 msb");
    runTx(3, 12, 1'b1, 2, 3, 16'h0B6D, "R1 R5 mode3 lsb");
    runTx(1, 16, 1'b0, 1, 2, 16'hC0DE, "R1 R4 mode1 len16");
    runTx(2, 1, 1'b1, 1, 4, 16'h0001, "R1 R4 mode2 len1");
    runRx(0, 8, 1'b0, 4, "R1 mode0 rx");
    runRx(3, 5, 1'b1, 3, "R5 mode3 rx lsb");
    runRx(2, 16, 1'b0, 2, "R4 mode2 rx len16");
    tFull();
    tIgnored();
    tBusy();
    tDivider();
    tTimeout();
    doneAll = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneAll) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule